// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave end of a 256-byte serial EEPROM that sits on a two-wire bus. It runs on a fast system clock and oversamples the bus clock and data lines. It detects START and STOP conditions and answers only to its own device select byte. That byte carries a fixed family code and three strap bits, so up to eight copies can share one bus. After a write select, the master sends a word address and then data bytes. These bytes collect in a 16-byte page buffer. They are written into the array by a timed internal write cycle that begins at the closing STOP. After a read select, the block shifts out bytes from its internal address pointer for as long as the master acknowledges them.

The data line is open-drain. The block only produces a pull-low enable. While the internal write cycle runs, the block ignores its own device select byte, so a master can poll for completion. A write-protect input freezes the whole array.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A device select byte is acknowledged only when its upper four bits are 1010 and bits 3..1 equal `strap`. Bit 0 selects read (1) or write (0). The acknowledge is SDA pulled low during the ninth SCL clock. Any other select byte leaves SDA released.
- R2: A write sequence (select, word address, data byte, STOP) stores the byte at the word address. A later read of that address returns it.
- R3: In a page write, the low four address bits advance after each data byte and wrap within the 16-byte page. The upper four bits stay fixed. Bytes outside the page are left unchanged.
- R4: While `wp` is 1, data bytes are still acknowledged. The array does not change and no internal write cycle starts. While `wp` is 0, the whole array is writable.
- R5: After a STOP that commits data, the device select byte is not acknowledged for `WR_CYCLES` clocks. After that time it is acknowledged again.
- R6: A random read (write select, word address, repeated START, read select) returns the byte at that address. A current-address read returns the byte that follows the last byte accessed.
- R7: In a sequential read, each master ACK moves to the next address, and address 255 rolls over to 0. A master NACK ends the read and SDA stays released.
- R8: SDA is only ever pulled low or released. The pull-low only starts while SCL is low.
- R9: After reset, SDA is released, every array byte reads FF and the address pointer is 0.
- R10: A write sequence that ends with STOP right after the word address starts no write cycle. It only moves the address pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire |
| strap | input | 3 | Low three bits of the device select address |
| wp | input | 1 | Write protect; 1 freezes the array, tie low when unused |
| sda_oe_n | output | 1 | Active-low pull-down enable for the data line |

## Verification
The bench covers these corner cases:
- A page write that crosses the top of its page. A design that carried into the upper address bits would corrupt the next page, and the bench checks that byte stays FF.
- A sequential read across address 255. A design without rollover would return the wrong byte.
- A device select sent at once after a STOP. A design that ignored the busy cycle would acknowledge it.
- A protected write. A design that stopped acknowledging data, or that still started a write cycle, would be seen by the acknowledge bits or by an immediate acknowledge on the next poll.
- A STOP that comes straight after the word address. A design that started a write cycle there would refuse the next select.

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave #(
  parameter int          WR_CYCLES  = 5000,
  parameter int          PAGE_BYTES = 16,
  parameter logic [3:0]  DEV_CODE   = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe_n
);
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = $clog2(PAGE_BYTES);
  localparam int BW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_WORD, S_WDAT, S_READ} st_t;

  logic [2:0] scl_p, sda_p;
  logic       scl_s, scl_q, sda_s, sda_q;
  logic       scl_rise, scl_fall, start_det, stop_det;

  st_t                  st;
  logic [3:0]           bitcnt;
  logic [7:0]           sr;
  logic [AW-1:0]        addr;
  logic                 rw, ack_ph, pull, mack;
  logic [7:0]           pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pmask;
  logic [BW-1:0]        busy_cnt;
  logic [7:0]           mem [DEPTH];
  logic [7:0]           rd_byte;
  logic                 dev_hit, commit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  assign scl_s     = scl_p[1];
  assign scl_q     = scl_p[2];
  assign sda_s     = sda_p[1];
  assign sda_q     = sda_p[2];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

  assign rd_byte  = mem[addr];
  assign dev_hit  = (sr[7:4] == DEV_CODE) && (sr[3:1] == strap) && (busy_cnt == '0);
  assign commit   = stop_det && (st == S_WDAT) && (|pmask) && !wp;
  assign sda_oe_n = ~pull;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st     <= S_IDLE;
      bitcnt <= '0;
      sr     <= '0;
      addr   <= '0;
      rw     <= 1'b0;
      ack_ph <= 1'b0;
      pull   <= 1'b0;
      mack   <= 1'b0;
      pmask  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pbuf[i] <= '0;
    end else if (start_det) begin
      st     <= S_DEV;
      bitcnt <= '0;
      ack_ph <= 1'b0;
      pull   <= 1'b0;
      pmask  <= '0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      ack_ph <= 1'b0;
      pull   <= 1'b0;
      pmask  <= '0;
    end else begin
      case (st)
        S_DEV, S_WORD, S_WDAT: begin
          if (scl_rise && !ack_ph && bitcnt < 4'd8) begin
            sr     <= {sr[6:0], sda_s};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && !ack_ph && bitcnt == 4'd8) begin
            ack_ph <= 1'b1;
            pull   <= 1'b1;
            case (st)
              S_DEV: begin
                if (!dev_hit) begin
                  st     <= S_IDLE;
                  ack_ph <= 1'b0;
                  pull   <= 1'b0;
                end else rw <= sr[0];
              end
              S_WORD: addr <= sr;
              S_WDAT: begin
                pbuf[addr[PW-1:0]] <= sr;
                if (!wp) pmask[addr[PW-1:0]] <= 1'b1;
                addr[PW-1:0] <= addr[PW-1:0] + PW'(1);
              end
              default: ;
            endcase
          end else if (scl_fall && ack_ph) begin
            ack_ph <= 1'b0;
            bitcnt <= '0;
            pull   <= 1'b0;
            if (st == S_DEV && rw) begin
              st   <= S_READ;
              sr   <= rd_byte;
              addr <= addr + AW'(1);
              pull <= ~rd_byte[7];
            end else if (st == S_DEV) st <= S_WORD;
            else if (st == S_WORD)    st <= S_WDAT;
          end
        end
        S_READ: begin
          if (!ack_ph) begin
            if (scl_rise) bitcnt <= bitcnt + 4'd1;
            else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                pull   <= 1'b0;
                ack_ph <= 1'b1;
              end else begin
                sr   <= {sr[6:0], 1'b0};
                pull <= ~sr[6];
              end
            end
          end else begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              ack_ph <= 1'b0;
              bitcnt <= '0;
              if (mack) begin
                sr   <= rd_byte;
                addr <= addr + AW'(1);
                pull <= ~rd_byte[7];
              end else begin
                st   <= S_IDLE;
                pull <= 1'b0;
              end
            end
          end
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (pmask[i]) mem[{addr[AW-1:PW], PW'(i)}] <= pbuf[i];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                busy_cnt <= '0;
    else if (commit)           busy_cnt <= BW'(WR_CYCLES);
    else if (busy_cnt != '0)   busy_cnt <= busy_cnt - BW'(1);

  AST_PULL_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(pull) |-> !scl_s); // R8
  AST_ACK_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rst_n) (ack_ph && st != S_READ) |-> pull); // R1
  AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n) (ack_ph && st == S_DEV) |-> (busy_cnt == '0)); // R5
  AST_BUSY_ONLY_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_cnt != '0) |-> $past(st == S_WDAT && !wp)); // R4
  AST_PAGE_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (st == S_WDAT && $past(st == S_WDAT)) |-> $stable(addr[AW-1:PW])); // R3
endmodule

// File: tb/sim_eeprom_i2c_slave.sv
module sim_eeprom_i2c_slave;
  localparam int WR = 200;
  localparam int Q  = 4;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEVR = {4'b1010, STRAP, 1'b1};
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h01C3, 16'h225A, 16'h7F00, 16'h80FF, 16'hA596, 16'h103C};

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, wp = 1'b0;
  logic sda_oe_n;
  wire  sda_bus = sda_m & sda_oe_n;
  int checks = 0, fails = 0, viol = 0;
  logic done = 1'b0;
  logic prev_oe = 1'b1, prev_scl = 1'b1;

  always #4 clk = ~clk;

  eeprom_i2c_slave #(.WR_CYCLES(WR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap(STRAP), .wp(wp), .sda_oe_n(sda_oe_n));

  always @(posedge clk) begin
    if (rst_n && prev_oe && !sda_oe_n && scl && prev_scl) viol++;
    prev_oe  <= sda_oe_n;
    prev_scl <= scl;
  end

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic i_start; sda_m = 1; tick(Q); scl = 1; tick(Q); sda_m = 0; tick(Q); scl = 0; tick(Q); endtask
  task automatic i_stop;  sda_m = 0; tick(Q); scl = 1; tick(Q); sda_m = 1; tick(Q); endtask
  task automatic bit_out(input logic b); sda_m = b; tick(Q); scl = 1; tick(2*Q); scl = 0; tick(Q); endtask
  task automatic bit_in(output logic b); sda_m = 1; tick(Q); scl = 1; tick(Q); b = sda_bus; tick(Q); scl = 0; tick(Q); endtask

  task automatic send(input logic [7:0] v, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv(input logic mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(~mack);
  endtask

  task automatic byte_write(input logic [7:0] a, input logic [7:0] d);
    logic k0, k1, k2;
    i_start; send(DEVW, k0); send(a, k1); send(d, k2); i_stop;
    chk("R2 write acks", {5'd0, k0, k1, k2}, 8'h07);
    tick(WR + 20);
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    logic k;
    i_start; send(DEVW, k); send(a, k); i_start; send(DEVR, k); recv(1'b0, d); i_stop;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run;
  end

  initial begin
    logic k, k1, k2, k3, k4;
    logic [7:0] d, d2;
    tick(5);
    chk("R9 sda released in reset", {7'd0, sda_oe_n}, 8'h01);
    rst_n = 1; tick(5);

    // R9 / R1: current-address read after reset
    i_start; send(DEVR, k); recv(1'b0, d); i_stop;
    chk("R1 select ack", {7'd0, k}, 8'h01);
    chk("R9 array erased at addr 0", d, 8'hFF);

    // R1: wrong family code and wrong strap
    i_start; send(8'hBA, k); i_stop;
    chk("R1 wrong code nack", {7'd0, k}, 8'h00);
    i_start; send(8'hA2, k); i_stop;
    chk("R1 wrong strap nack", {7'd0, k}, 8'h00);

    // Table of byte writes and random reads: R2, R6
    for (int i = 0; i < NV; i++) begin
      byte_write(VEC[i][15:8], VEC[i][7:0]);
      rand_read(VEC[i][15:8], d);
      chk("R2 R6 random read back", d, VEC[i][7:0]);
    end

    // R5: busy polling
    i_start; send(DEVW, k); send(8'h50, k); send(8'h66, k); i_stop;
    i_start; send(DEVW, k); i_stop;
    chk("R5 nack while busy", {7'd0, k}, 8'h00);
    tick(WR);
    i_start; send(DEVW, k); i_stop;
    chk("R5 ack after write time", {7'd0, k}, 8'h01);
    rand_read(8'h50, d);
    chk("R5 byte committed", d, 8'h66);

    // R3: page write crossing the top of the page
    i_start; send(DEVW, k); send(8'h3E, k);
    send(8'h11, k1); send(8'h22, k2); send(8'h33, k3); send(8'h44, k4); i_stop;
    chk("R3 page acks", {4'd0, k1, k2, k3, k4}, 8'h0F);
    tick(WR + 20);
    rand_read(8'h3E, d); chk("R3 3E", d, 8'h11);
    rand_read(8'h3F, d); chk("R3 3F", d, 8'h22);
    rand_read(8'h30, d); chk("R3 wrap 30", d, 8'h33);
    rand_read(8'h31, d); chk("R3 wrap 31", d, 8'h44);
    rand_read(8'h40, d); chk("R3 next page untouched", d, 8'hFF);

    // R4: write protect
    wp = 1;
    i_start; send(DEVW, k1); send(8'h10, k2); send(8'h55, k3); i_stop;
    chk("R4 protected data acked", {5'd0, k1, k2, k3}, 8'h07);
    i_start; send(DEVW, k); i_stop;
    chk("R4 no write cycle", {7'd0, k}, 8'h01);
    rand_read(8'h10, d);
    chk("R4 array unchanged", d, 8'h3C);
    wp = 0;

    // R7: sequential read across 255 -> 0
    byte_write(8'hFF, 8'h77);
    byte_write(8'h00, 8'h88);
    i_start; send(DEVW, k); send(8'hFF, k); i_start; send(DEVR, k);
    recv(1'b1, d); recv(1'b0, d2); i_stop;
    chk("R7 byte at FF", d, 8'h77);
    chk("R7 rollover to 00", d2, 8'h88);
    tick(4);
    chk("R7 released after nack", {7'd0, sda_oe_n}, 8'h01);

    // R6: current-address read continues at 01
    i_start; send(DEVR, k); recv(1'b0, d); i_stop;
    chk("R6 current address", d, 8'hC3);

    // R10: word address only, then STOP
    i_start; send(DEVW, k); send(8'h22, k); i_stop;
    i_start; send(DEVW, k); i_stop;
    chk("R10 no write cycle", {7'd0, k}, 8'h01);
    i_start; send(DEVR, k); recv(1'b0, d); i_stop;
    chk("R10 pointer moved", d, 8'h5A);

    chk("R8 pull started only with SCL low", viol[7:0], 8'h00);
    finish_run;
  end
endmodule